// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits on the controller side of a single four-bank synchronous DRAM. It drives the command pins, bank select, address bus and clock enable. It brings the device up after reset, keeps it refreshed, and turns single burst requests from a user port into activate, column-access and precharge commands. It never issues a command before the minimum clock count since the command it depends on has elapsed. All timing limits are parameters in clocks. The defaults assume a 5 ns clock: 3 clocks from activate to column access, 3 for precharge, 8 for the minimum open-row time, 11 for the same-bank activate cycle and for a refresh, 2 between activates to different banks, and 2 after a mode load.

A user presents a transfer with a valid/ready handshake. The transfer carries a direction bit, a bank, a row and a column. The transfer is taken on the clock edge where both valid and ready are high, and the activate leaves on that same edge. Each row is closed again once its burst is done, so every bank is precharged whenever the sequencer is idle. A refresh timer raises a pending flag every 3120 clocks, which gives 4096 refreshes in 64 ms. A pending refresh goes ahead of any new transfer. Data movement, power-down and self refresh are outside the block, and the clock enable stays high.

Top module: `sdram_cmd_seq`

## Requirements
- R1: From reset the outputs carry NOP (chip select, RAS, CAS, WE = 0,1,1,1) with address and bank 0 and ready low. NOP continues until clock edge INIT_CYC after reset release (default 40000), where a precharge with address bit 10 set is issued to close all banks.
- R2: After that precharge, the first auto refresh follows T_RP edges later. A second one follows T_RFC edges after the first, and the mode load follows T_RFC edges after the second. Ready stays low until T_MRD edges after the mode load.
- R3: The mode load carries bank 0. Its address holds the burst-length code in bits 2..0 (1,2,4,8 give 0,1,2,3), 0 in bit 3 for sequential order, the CAS latency in bits 6..4, and 0 in every other bit. The defaults (burst 8, latency 3) give 12'h033.
- R4: Commands as {chip select, RAS, CAS, WE} are: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode load 0000, NOP 0111. Burst stop (0110) is never issued.
- R5: A transfer is accepted on an edge where valid and ready are both high. The activate appears on that edge with the transfer's bank on the bank pins and its row on the address pins.
- R6: The read (direction 0) or write (direction 1) follows the activate by exactly T_RCD edges. It carries the same bank and the column in address bits 8..0, with bit 10 and all other bits 0, so no auto-precharge is requested.
- R7: A precharge of that bank alone (address all 0, bit 10 clear) follows the column command. For a write the gap is BURST_LEN-1+T_WR edges; for a read it is BURST_LEN edges. Either gap is raised if needed so the row stays open at least T_RAS edges (defaults: 9 for a write, 8 for a read).
- R8: No command is issued for T_RP edges after a precharge. An activate comes at least T_RC edges after the previous activate to the same bank, and at least T_RRD edges after any activate. Every edge without a due command carries NOP.
- R9: The refresh timer starts with the mode load. It raises a pending refresh every REF_INT edges (default 3120), and that pending refresh becomes visible on the next edge. While it is pending, ready is low. It is issued as soon as the sequencer is idle with all banks precharged, and nothing else waiting may go first.
- R10: After a refresh no command is issued for T_RFC edges.
- R11: The clock-enable output is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A transfer is presented |
| req_ready | output | 1 | The transfer would be taken on this edge |
| req_write | input | 1 | 1 for a write burst, 0 for a read burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row to open |
| req_col | input | 9 | Starting column of the burst |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row/column/mode address |

## Verification
The bench runs the whole 200 us power-up. It then keeps transfers coming back to back, so that refresh ticks land while a request is waiting and while a burst is still closing its row. A sequencer that let the request go first, or that lost a pending refresh, would show up on the first such collision. Writes and reads alternate and repeat on the same bank, so the two column-to-precharge gaps and the post-precharge quiet time are checked separately. A design that used the read gap for writes would close the row one clock early, before write recovery ends. A column command with the auto-precharge bit set, a wrong mode-word field, or any command one edge off its schedule shows up as a mismatch against the bench's schedule of expected commands.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    localparam int BANK_W    = 2;
    localparam int ROW_W     = 12;
    localparam int COL_W     = 9;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int AP_BIT    = 10;

    // {chip select, row strobe, column strobe, write enable}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    // Each state names the next command to issue once the gap timer is zero
    typedef enum logic [2:0] {
        SQ_POWERUP,
        SQ_BOOT_REF_A,
        SQ_BOOT_REF_B,
        SQ_BOOT_MODE,
        SQ_IDLE,
        SQ_ACCESS,
        SQ_CLOSE
    } seq_state_e;

    typedef struct packed {
        logic               wr;
        logic [BANK_W-1:0]  bank;
        logic [COL_W-1:0]   col;
    } xfer_t;

    typedef struct packed {
        sd_cmd_e            cmd;
        logic [BANK_W-1:0]  ba;
        logic [ROW_W-1:0]   addr;
    } sd_bus_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [2:0] burst_code(input int bl);
        case (bl)
            1:       return 3'd0;
            2:       return 3'd1;
            4:       return 3'd2;
            8:       return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [ROW_W-1:0] mode_word(input int bl, input int cl);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[2:0] = burst_code(bl);
        m[6:4] = 3'(cl);
        return m;
    endfunction

    // Edges from column command to precharge of the same bank
    function automatic int col_to_close(input bit wr, input int bl, input int twr,
                                        input int trcd, input int tras);
        int g;
        g = wr ? (bl - 1 + twr) : bl;
        return imax(g, tras - trcd);
    endfunction

endpackage

// File: rtl/sdseq_refresh_sched.sv
module sdseq_refresh_sched #(
    parameter int REF_INT = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ref_done,
    output logic ref_pend
);
    localparam int CW = $clog2(REF_INT);
    localparam logic [CW-1:0] LAST = CW'(REF_INT - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            ref_pend <= 1'b0;
        end else begin
            if (run) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
            if (wrap) begin
                ref_pend <= 1'b1;
            end else if (ref_done) begin
                ref_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdseq_bank_guard.sv
module sdseq_bank_guard #(
    parameter int NUM_BANKS = 4,
    parameter int T_RC      = 11,
    parameter int T_RRD     = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         act_fire,
    input  logic [$clog2(NUM_BANKS)-1:0] act_bank,
    output logic [NUM_BANKS-1:0]         bank_free
);
    localparam int RC_W  = $clog2(T_RC + 1);
    localparam int RRD_W = $clog2(T_RRD + 1);

    logic [RRD_W-1:0] rrd_q;
    logic             rrd_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rrd_q <= '0;
        end else if (act_fire) begin
            rrd_q <= RRD_W'(T_RRD - 1);
        end else if (rrd_q != '0) begin
            rrd_q <= rrd_q - 1'b1;
        end
    end

    assign rrd_ok = (rrd_q == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [RC_W-1:0] rc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                rc_q <= '0;
            end else if (act_fire && (act_bank == b)) begin
                rc_q <= RC_W'(T_RC - 1);
            end else if (rc_q != '0) begin
                rc_q <= rc_q - 1'b1;
            end
        end
        assign bank_free[b] = rrd_ok && (rc_q == '0);
    end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq import sdseq_pkg::*; #(
    parameter int INIT_CYC  = 40000,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 8,
    parameter int T_RC      = 11,
    parameter int T_RRD     = 2,
    parameter int T_RFC     = 11,
    parameter int T_MRD     = 2,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 8,
    parameter int CAS_LAT   = 3,
    parameter int REF_INT   = 3120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr
);
    localparam int GAP_WR_I = col_to_close(1'b1, BURST_LEN, T_WR, T_RCD, T_RAS);
    localparam int GAP_RD_I = col_to_close(1'b0, BURST_LEN, T_WR, T_RCD, T_RAS);
    localparam int MAX_GAP  = imax(INIT_CYC, imax(imax(T_RFC, T_RP),
                                   imax(imax(GAP_WR_I, GAP_RD_I), imax(T_RCD, T_MRD))));
    localparam int GAP_W    = $clog2(MAX_GAP + 1);

    localparam logic [GAP_W-1:0] LD_INIT = GAP_W'(INIT_CYC - 1);
    localparam logic [GAP_W-1:0] LD_RP   = GAP_W'(T_RP - 1);
    localparam logic [GAP_W-1:0] LD_RFC  = GAP_W'(T_RFC - 1);
    localparam logic [GAP_W-1:0] LD_MRD  = GAP_W'(T_MRD - 1);
    localparam logic [GAP_W-1:0] LD_RCD  = GAP_W'(T_RCD - 1);
    localparam logic [GAP_W-1:0] LD_GWR  = GAP_W'(GAP_WR_I - 1);
    localparam logic [GAP_W-1:0] LD_GRD  = GAP_W'(GAP_RD_I - 1);
    localparam logic [ROW_W-1:0] MODE_VAL = mode_word(BURST_LEN, CAS_LAT);

    seq_state_e          state_q, state_d;
    logic [GAP_W-1:0]    gap_q, gap_d;
    xfer_t               xfer_q, xfer_d;
    sd_bus_t             bus_q, bus_d;
    logic                boot_done_q, boot_done_d;
    logic                fire_ref, fire_act;
    logic                ref_pend;
    logic [NUM_BANKS-1:0] bank_free;
    logic                gap_zero;

    sdseq_refresh_sched #(
        .REF_INT (REF_INT)
    ) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .run      (boot_done_q),
        .ref_done (fire_ref),
        .ref_pend (ref_pend)
    );

    sdseq_bank_guard #(
        .NUM_BANKS (NUM_BANKS),
        .T_RC      (T_RC),
        .T_RRD     (T_RRD)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .act_fire  (fire_act),
        .act_bank  (req_bank),
        .bank_free (bank_free)
    );

    assign gap_zero = (gap_q == '0);

    always_comb begin
        state_d     = state_q;
        gap_d       = gap_zero ? gap_q : gap_q - 1'b1;
        xfer_d      = xfer_q;
        boot_done_d = boot_done_q;
        bus_d       = '{cmd: CMD_NOP, ba: '0, addr: '0};
        fire_ref    = 1'b0;
        fire_act    = 1'b0;
        req_ready   = 1'b0;

        case (state_q)
            SQ_POWERUP: if (gap_zero) begin
                bus_d.cmd          = CMD_PRE;
                bus_d.addr[AP_BIT] = 1'b1;
                gap_d              = LD_RP;
                state_d            = SQ_BOOT_REF_A;
            end
            SQ_BOOT_REF_A: if (gap_zero) begin
                bus_d.cmd = CMD_REF;
                gap_d     = LD_RFC;
                state_d   = SQ_BOOT_REF_B;
            end
            SQ_BOOT_REF_B: if (gap_zero) begin
                bus_d.cmd = CMD_REF;
                gap_d     = LD_RFC;
                state_d   = SQ_BOOT_MODE;
            end
            SQ_BOOT_MODE: if (gap_zero) begin
                bus_d.cmd   = CMD_MRS;
                bus_d.addr  = MODE_VAL;
                gap_d       = LD_MRD;
                boot_done_d = 1'b1;
                state_d     = SQ_IDLE;
            end
            SQ_IDLE: begin
                if (gap_zero && ref_pend) begin
                    bus_d.cmd = CMD_REF;
                    gap_d     = LD_RFC;
                    fire_ref  = 1'b1;
                end else begin
                    req_ready = gap_zero && !ref_pend && bank_free[req_bank];
                    if (req_ready && req_valid) begin
                        bus_d.cmd  = CMD_ACT;
                        bus_d.ba   = req_bank;
                        bus_d.addr = req_row;
                        xfer_d     = '{wr: req_write, bank: req_bank, col: req_col};
                        gap_d      = LD_RCD;
                        fire_act   = 1'b1;
                        state_d    = SQ_ACCESS;
                    end
                end
            end
            SQ_ACCESS: if (gap_zero) begin
                bus_d.cmd  = xfer_q.wr ? CMD_WR : CMD_RD;
                bus_d.ba   = xfer_q.bank;
                bus_d.addr = ROW_W'(xfer_q.col);
                gap_d      = xfer_q.wr ? LD_GWR : LD_GRD;
                state_d    = SQ_CLOSE;
            end
            SQ_CLOSE: if (gap_zero) begin
                bus_d.cmd = CMD_PRE;
                bus_d.ba  = xfer_q.bank;
                gap_d     = LD_RP;
                state_d   = SQ_IDLE;
            end
            default: state_d = SQ_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SQ_POWERUP;
            gap_q       <= LD_INIT;
            xfer_q      <= '0;
            boot_done_q <= 1'b0;
            bus_q       <= '{cmd: CMD_NOP, ba: '0, addr: '0};
        end else begin
            state_q     <= state_d;
            gap_q       <= gap_d;
            xfer_q      <= xfer_d;
            boot_done_q <= boot_done_d;
            bus_q       <= bus_d;
        end
    end

    assign sd_cke   = 1'b1;
    assign sd_cs_n  = bus_q.cmd[3];
    assign sd_ras_n = bus_q.cmd[2];
    assign sd_cas_n = bus_q.cmd[1];
    assign sd_we_n  = bus_q.cmd[0];
    assign sd_ba    = bus_q.ba;
    assign sd_addr  = bus_q.addr;
endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker import sdseq_pkg::*; #(
    parameter int T_RCD = 3,
    parameter int T_RAS = 8,
    parameter int T_RP  = 3,
    parameter int T_RFC = 11,
    parameter int T_MRD = 2
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ap
);
    sd_cmd_e    cmd;
    logic [7:0] since_act, since_pre, since_ref, since_mrs;
    logic       row_open;

    assign cmd = sd_cmd_e'({cs_n, ras_n, cas_n, we_n});

    function automatic logic [7:0] bump(input logic [7:0] v);
        return (v == 8'hff) ? v : v + 8'd1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= 8'hff;
            since_pre <= 8'hff;
            since_ref <= 8'hff;
            since_mrs <= 8'hff;
            row_open  <= 1'b0;
        end else begin
            since_act <= (cmd == CMD_ACT) ? 8'd1 : bump(since_act);
            since_pre <= (cmd == CMD_PRE) ? 8'd1 : bump(since_pre);
            since_ref <= (cmd == CMD_REF) ? 8'd1 : bump(since_ref);
            since_mrs <= (cmd == CMD_MRS) ? 8'd1 : bump(since_mrs);
            if (cmd == CMD_ACT)      row_open <= 1'b1;
            else if (cmd == CMD_PRE) row_open <= 1'b0;
        end
    end

    a_r4_no_burst_stop: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_BST);

    a_r6_act_to_col: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (since_act >= 8'(T_RCD) && !ap));

    a_r7_row_open_min: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && !ap) |-> since_act >= 8'(T_RAS));

    a_r8_pre_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> since_pre >= 8'(T_RP));

    a_r9_ref_when_closed: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> !row_open);

    a_r10_ref_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> since_ref >= 8'(T_RFC));

    a_r2_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |-> since_mrs >= 8'(T_MRD));
endmodule

bind sdram_cmd_seq sdseq_checker #(
    .T_RCD (T_RCD),
    .T_RAS (T_RAS),
    .T_RP  (T_RP),
    .T_RFC (T_RFC),
    .T_MRD (T_MRD)
) u_sdseq_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .ap    (sd_addr[10])
);

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;
    localparam int INIT  = 40000;
    localparam int TRP   = 3;
    localparam int TRCD  = 3;
    localparam int TRAS  = 8;
    localparam int TRC   = 11;
    localparam int TRRD  = 2;
    localparam int TRFC  = 11;
    localparam int TMRD  = 2;
    localparam int TWR   = 2;
    localparam int BL    = 8;
    localparam int REFI  = 3120;

    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                           PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    typedef struct {
        int          t;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        string       tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    // reference model state
    ev_t         sched[$];
    int          e = 0;
    bit          booted = 0;
    int          busy = 0, next_tick = 0, ref_quiet = 0, boot_edge = 0;
    int          last_act[4] = '{-1000, -1000, -1000, -1000};
    int          last_any = -1000;
    logic [3:0]  ex_cmd = NOP;
    logic [1:0]  ex_ba = '0;
    logic [11:0] ex_addr = '0;
    logic        ex_rdy = 1'b0;
    string       ex_tag = "R1";

    always #5 clk = ~clk;

    sdram_cmd_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    function automatic int close_gap(input logic w);
        int g;
        g = w ? (BL - 1 + TWR) : BL;   // R7 write recovery or read burst
        if (g < TRAS - TRCD) g = TRAS - TRCD;
        return g;
    endfunction

    function automatic bit bank_ok(input int at, input logic [1:0] b);
        return (at >= last_act[b] + TRC) && (at >= last_any + TRRD);  // R8
    endfunction

    function automatic void push_ev(input int t, input logic [3:0] c, input logic [1:0] b,
                                    input logic [11:0] a, input string tg);
        ev_t x;
        x.t = t; x.cmd = c; x.ba = b; x.addr = a; x.tag = tg;
        sched.push_back(x);
    endfunction

    // reference model: one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            e = 0;
            sched.delete();
            push_ev(INIT, PRE, 2'd0, 12'h400, "R1");
            push_ev(INIT + TRP, REF, 2'd0, 12'h000, "R2");
            push_ev(INIT + TRP + TRFC, REF, 2'd0, 12'h000, "R2");
            push_ev(INIT + TRP + 2 * TRFC, MRS, 2'd0, 12'h033, "R3");
            ex_cmd = NOP; ex_ba = '0; ex_addr = '0; ex_rdy = 1'b0; ex_tag = "R1";
        end else begin
            e++;
            ex_cmd = NOP; ex_ba = '0; ex_addr = '0;
            ex_tag = (e < ref_quiet) ? "R10" : "R8";
            if (sched.size() > 0 && sched[0].t == e) begin
                ev_t x;
                x = sched.pop_front();
                ex_cmd = x.cmd; ex_ba = x.ba; ex_addr = x.addr; ex_tag = x.tag;
                if (x.cmd == MRS) begin
                    booted = 1; boot_edge = e;
                    busy = e + TMRD; next_tick = e + REFI;
                end
                if (x.cmd == REF) ref_quiet = e + TRFC;
            end else if (booted && sched.size() == 0 && e >= busy) begin
                if (next_tick < e) begin
                    ex_cmd = REF; ex_tag = "R9";
                    busy = e + TRFC; ref_quiet = e + TRFC;
                    next_tick += REFI;
                end else if (req_valid && bank_ok(e, req_bank)) begin
                    int g;
                    ex_cmd = ACT; ex_ba = req_bank; ex_addr = req_row; ex_tag = "R5";
                    last_act[req_bank] = e; last_any = e;
                    g = close_gap(req_write);
                    push_ev(e + TRCD, req_write ? WR : RD, req_bank, {3'b000, req_col}, "R6");
                    push_ev(e + TRCD + g, PRE, req_bank, 12'h000, "R7");
                    busy = e + TRCD + g + TRP;
                end
            end
            ex_rdy = booted && sched.size() == 0 && (e + 1 >= busy) &&
                     !(next_tick < e + 1) && bank_ok(e + 1, req_bank);
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!finished) begin
            logic [3:0] got;
            got = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            n_cmp++;
            if (sd_cke !== 1'b1) begin
                n_bad++;
                $display("FAIL R11 edge %0d: cke=%b expected 1", e, sd_cke);
            end else if (got !== ex_cmd || sd_ba !== ex_ba || sd_addr !== ex_addr) begin
                n_bad++;
                $display("FAIL %s R4 edge %0d: cmd=%b ba=%0d addr=%h expected cmd=%b ba=%0d addr=%h",
                         ex_tag, e, got, sd_ba, sd_addr, ex_cmd, ex_ba, ex_addr);
            end else if (req_ready !== ex_rdy) begin
                n_bad++;
                $display("FAIL %s edge %0d: ready=%b expected %b",
                         booted ? "R9" : "R2", e, req_ready, ex_rdy);
            end
        end
    end

    task automatic do_req(input logic w, input logic [1:0] b, input logic [11:0] r,
                          input logic [8:0] c);
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = w; req_bank = b; req_row = r; req_col = c;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, cycle %0d expected < 150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;   // R1 reset state compared above while rst is high
        wait (booted);
        // R5 R6 R7 R8 R9: steady traffic across two refresh intervals
        for (int i = 0; e < boot_edge + 2 * REFI + 200; i++) begin
            do_req(i[0] ^ i[2], 2'((i / 2) % 4), 12'((i * 37) & 12'hfff),
                   9'((i * 13) & 9'h1ff));
            if (i % 5 == 4) repeat (i % 7) @(negedge clk);
        end
        // final idle stretch: only NOP and refresh may appear (R8)
        repeat (40) @(negedge clk);
        finish_run();
    end
endmodule